// File: doc/BRIEF.md
# Selectable-Polarity Bit Population Counter

This block reports how many bits of a parameter-sized input word are at a chosen level. A compile-time mode picks the level: either the bits that are high or the bits that are low are counted. The tally is formed combinationally from fixed-size slices of the word. Each slice is counted on its own, and the slice results are then summed.

The result sits in a register that loads only on a rising clock edge where the write strobe is high. At every other time the register holds its last value. An asynchronous active-low reset clears the register. The width of the result is a separate parameter, and elaboration stops if that width cannot hold the largest possible count.

Top module: `popcnt_unit`

## Requirements
- R1: While `rst_ni` is low, `cnt_o` is 0, and it becomes 0 as soon as `rst_ni` falls, without waiting for a clock edge.
- R2: With `MODE` = `CNT_ONES`, a rising edge with `wr_en_i` high loads `cnt_o` with the number of bits of `data_i` equal to 1, sampled at that edge.
- R3: With `MODE` = `CNT_ZEROS`, a rising edge with `wr_en_i` high loads `cnt_o` with the number of bits of `data_i` equal to 0, sampled at that edge.
- R4: A rising edge with `wr_en_i` low leaves `cnt_o` unchanged, whatever `data_i` carries.
- R5: An all-ones `data_i` gives `IN_W` in `CNT_ONES` mode and 0 in `CNT_ZEROS` mode. An all-zeros `data_i` gives 0 in `CNT_ONES` mode and `IN_W` in `CNT_ZEROS` mode.
- R6: `cnt_o` holds the full count `IN_W` without wrapping. Elaboration fails when `CNT_W` is less than clog2(`IN_W`+1); for example, an 8-bit input needs at least 4 count bits.
- R7: `cnt_o` never exceeds `IN_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the count register loads on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the count |
| wr_en_i | input | 1 | Write strobe; when high, the new count is loaded at the edge |
| data_i | input | IN_W | Word whose bits are counted |
| cnt_o | output | CNT_W | Registered count of bits at the selected level |

## Verification
The clocked properties assume that `data_i` and `wr_en_i` are known, non-X values at every rising edge after reset is released. They also assume that `rst_ni` is released away from a clock edge. The bench meets both assumptions by driving every input from time zero. It changes the inputs and `rst_ni` only on falling edges, so each value is stable half a period before the next rising edge samples it. Two instances, one per mode, receive identical stimulus, which lets a single vector check both polarities at once.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

  typedef enum logic {
    CNT_ONES  = 1'b0,
    CNT_ZEROS = 1'b1
  } count_mode_e;

  // minimum result width able to hold the value n
  function automatic int unsigned min_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/popcnt_chunk.sv
module popcnt_chunk #(
  parameter int unsigned CHUNK_W = 4,
  localparam int unsigned CC_W   = popcnt_pkg::min_cnt_w(CHUNK_W)
) (
  input  logic [CHUNK_W-1:0] bits_i,
  output logic [CC_W-1:0]    cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int unsigned b = 0; b < CHUNK_W; b++) begin
      cnt_o = cnt_o + CC_W'(bits_i[b]);
    end
  end

endmodule

// File: rtl/popcnt_sum.sv
module popcnt_sum
  import popcnt_pkg::*;
#(
  parameter int unsigned IN_W     = 8,
  parameter int unsigned CHUNK_W  = 4,
  parameter count_mode_e MODE     = CNT_ONES,
  localparam int unsigned SUM_W   = min_cnt_w(IN_W)
) (
  input  logic [IN_W-1:0]  data_i,
  output logic [SUM_W-1:0] sum_o
);

  localparam int unsigned N_CHUNK = (IN_W + CHUNK_W - 1) / CHUNK_W;
  localparam int unsigned PAD_W   = N_CHUNK * CHUNK_W;
  localparam int unsigned CC_W    = min_cnt_w(CHUNK_W);

  logic [IN_W-1:0]  sel_w;
  logic [PAD_W-1:0] pad_w;
  logic [CC_W-1:0]  chunk_cnt [N_CHUNK];

  // polarity fixed at elaboration
  if (MODE == CNT_ZEROS) begin : g_zeros
    assign sel_w = ~data_i;
  end else begin : g_ones
    assign sel_w = data_i;
  end

  // padding is applied after inversion so it is never counted
  always_comb begin
    pad_w = '0;
    pad_w[IN_W-1:0] = sel_w;
  end

  for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
    popcnt_chunk #(.CHUNK_W(CHUNK_W)) chunk_i (
      .bits_i (pad_w[c*CHUNK_W +: CHUNK_W]),
      .cnt_o  (chunk_cnt[c])
    );
  end

  always_comb begin
    sum_o = '0;
    for (int unsigned c = 0; c < N_CHUNK; c++) begin
      sum_o = sum_o + SUM_W'(chunk_cnt[c]);
    end
  end

  always_comb begin
    assert_sum_bound_R7: assert (int'(sum_o) <= int'(IN_W));
  end

endmodule

// File: rtl/popcnt_unit.sv
module popcnt_unit
  import popcnt_pkg::*;
#(
  parameter int unsigned IN_W    = 8,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned CHUNK_W = 4,
  parameter count_mode_e MODE    = CNT_ONES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IN_W-1:0]  data_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int unsigned SUM_W = min_cnt_w(IN_W);

  initial begin
    assert_cnt_width_R6: assert (CNT_W >= SUM_W)
      else $error("CNT_W=%0d cannot hold %0d", CNT_W, IN_W);
  end

  logic [SUM_W-1:0] sum_w;
  logic [CNT_W-1:0] cnt_q;

  popcnt_sum #(
    .IN_W    (IN_W),
    .CHUNK_W (CHUNK_W),
    .MODE    (MODE)
  ) sum_i (
    .data_i (data_i),
    .sum_o  (sum_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_en_i) cnt_q <= CNT_W'(sum_w);
  end

  assign cnt_o = cnt_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cnt_o));

  if (MODE == CNT_ONES) begin : g_chk_ones
    assert_ones_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> int'(cnt_o) == $countones($past(data_i)));
    assert_all_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && &data_i) |=> int'(cnt_o) == int'(IN_W));
  end else begin : g_chk_zeros
    assert_zeros_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> int'(cnt_o) == int'(IN_W) - $countones($past(data_i)));
    assert_all_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && &data_i) |=> cnt_o == '0);
  end

  assert_out_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_o) <= int'(IN_W));

endmodule

// File: tb/popcnt_unit_tb_top.sv
`timescale 1ns/1ps
module popcnt_unit_tb_top;
  import popcnt_pkg::*;

  localparam int unsigned IN_W  = 8;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned N_VEC = 14;

  // {data, expected number of ones}
  localparam logic [11:0] VEC_TBL [N_VEC] = '{
    {8'h00, 4'd0}, {8'hFF, 4'd8}, {8'h01, 4'd1}, {8'h80, 4'd1},
    {8'h55, 4'd4}, {8'hAA, 4'd4}, {8'h0F, 4'd4}, {8'hF0, 4'd4},
    {8'h7F, 4'd7}, {8'hFE, 4'd7}, {8'h3C, 4'd4}, {8'h81, 4'd2},
    {8'h13, 4'd3}, {8'hE9, 4'd5}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [IN_W-1:0]  data = '0;
  logic [CNT_W-1:0] cnt_ones, cnt_zeros;
  int               n_cmp = 0;
  int               n_bad = 0;
  bit               done = 1'b0;

  always #2.5 clk = ~clk;

  popcnt_unit #(.IN_W(IN_W), .CNT_W(CNT_W), .MODE(CNT_ONES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .data_i(data), .cnt_o(cnt_ones)
  );

  popcnt_unit #(.IN_W(IN_W), .CNT_W(CNT_W), .MODE(CNT_ZEROS)) dut_z_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .data_i(data), .cnt_o(cnt_zeros)
  );

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (data=%h)", req, got, exp, data);
    end
  endtask

  function automatic int ref_ones(input logic [IN_W-1:0] v);
    int n = 0;
    for (int b = 0; b < int'(IN_W); b++) if (v[b] == 1'b1) n++;
    return n;
  endfunction

  // drive at falling edge, capture on rising edge, sample at next falling edge
  task automatic write_vec(input logic [IN_W-1:0] v);
    @(negedge clk);
    data  = v;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    // R1: held in reset with strobe active
    data  = 8'hA5;
    wr_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ones", cnt_ones, 0);
    check("R1 zeros", cnt_zeros, 0);
    wr_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 / R3
    for (int i = 0; i < int'(N_VEC); i++) begin
      write_vec(VEC_TBL[i][11:4]);
      check("R2", cnt_ones, int'(VEC_TBL[i][3:0]));
      check("R3", cnt_zeros, int'(IN_W) - int'(VEC_TBL[i][3:0]));
    end

    // random vectors against the bench reference
    for (int i = 0; i < 40; i++) begin
      write_vec(IN_W'($urandom));
      check("R2 rand", cnt_ones, ref_ones(data));
      check("R3 rand", cnt_zeros, int'(IN_W) - ref_ones(data));
      check("R7", int'(cnt_ones) <= int'(IN_W) ? 1 : 0, 1);
    end

    // R5 / R6 corners
    write_vec('1);
    check("R5 ones all-ones", cnt_ones, int'(IN_W));
    check("R6 no wrap", cnt_ones, 8);
    check("R5 zeros all-ones", cnt_zeros, 0);
    write_vec('0);
    check("R5 ones all-zeros", cnt_ones, 0);
    check("R6 zeros no wrap", cnt_zeros, int'(IN_W));

    // R4: strobe low, data changes, output must hold
    write_vec(8'h07);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      data = IN_W'($urandom) | 8'h80;
      @(negedge clk);
      check("R4 ones hold", cnt_ones, 3);
      check("R4 zeros hold", cnt_zeros, 5);
    end

    // R1: asynchronous reset mid-run
    write_vec(8'hFF);
    rst_n = 1'b0;
    #1;
    check("R1 async ones", cnt_ones, 0);
    check("R1 async zeros", cnt_zeros, int'(0));
    @(negedge clk);
    rst_n = 1'b1;
    write_vec(8'h3F);
    check("R2 after reset", cnt_ones, 6);
    check("R3 after reset", cnt_zeros, 2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule